// File: doc/BRIEF.md
# General-Purpose Input SMI Enable and Status Bank

This block keeps the per-input enable and latched-event state for sixteen general-purpose inputs. These inputs may raise a system-management interrupt (SMI). Each input first passes through a two-flop synchronizer. A rising edge of the synchronized level latches a sticky status bit. Software clears that bit by writing a one to it.

Software reaches two 16-bit registers through a small register port. The port uses a write strobe, an offset, and a combinational read path. Bit n of each register belongs to input n.

Each input has its own 2-bit route field, supplied as a 32-bit configuration word. An input drives the active-low SMI output only when three things hold together:

- its enable bit is set;
- its route field selects SMI;
- the input is marked as implemented by a build-time mask.

A sticky summary event flag rises together with the SMI output. Software clears that flag through its own strobe.

The block resets only on its own asynchronous reset, which stands for the always-on domain reset. The ordinary platform reset does not reach it.

Top module: `gpi_smi_regs`

## Requirements
- R1: The enable register is read and written at offset 0x38. It reads 0x0000 after reset, and a write stores the written data.
- R2: The status register is read at offset 0x3A and reads 0x0000 after reset. When input n goes high, status bit n is still 0 after two rising clock edges and is 1 after the third.
- R3: A set status bit stays 1 after its input returns low, until software clears it.
- R4: Writing to offset 0x3A clears each status bit whose written data bit is 1. Data bits that are 0 leave status unchanged.
- R5: If a rising edge sets a status bit in the same cycle that a write-1 clears it, the bit ends up 1.
- R6: Inputs whose bit is 0 in the IMPL_MASK parameter behave as absent. Their enable and status bits read 0, ignore writes, and never set.
- R7: smi_no_o is 0 exactly when some input n has status, enable and implemented all true and route bits [2n+1:2n] equal 01. The route encodings 00 (none), 10 (SCI) and 11 (reserved) never assert it.
- R8: smi_no_o returns to 1 in the cycle after the write that clears the last qualifying status bit.
- R9: gpe_sts_o is 1 whenever smi_no_o is 0. Once set it stays 1 until a gpe_clr_i pulse arrives while no qualifying bit is pending. A pulse during a pending condition has no effect.
- R10: Reads at any offset other than 0x38 and 0x3A return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gpi_i | input | 16 | Raw general-purpose input levels |
| route_i | input | 32 | Route field per input, 2 bits each (00 none, 01 SMI, 10 SCI, 11 reserved) |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register offset from the power-management base |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| gpe_clr_i | input | 1 | Write-1 clear strobe for the summary flag |
| smi_no_o | output | 1 | Active-low SMI request |
| gpe_sts_o | output | 1 | Sticky summary event flag |

## Verification
The checker assumes route_i stays steady when an enable or status bit for that input changes. It also assumes gpi_i meets no timing beyond what the synchronizer absorbs. The bench therefore sets each route field before an input is pulsed and holds it until the status has been cleared. Inputs, strobes and routes are driven at falling clock edges.

The bench walks every input through every route encoding under an implemented mask that has two absent inputs. It confirms the three-edge latency, stickiness, clear behaviour, set priority and the summary flag at each step.

// File: rtl/gpi_smi_pkg.sv
package gpi_smi_pkg;
  localparam int unsigned ROUTE_W = 2;

  typedef enum logic [ROUTE_W-1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_SMI  = 2'b01,
    ROUTE_SCI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
  parameter int unsigned N_GPI = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_GPI-1:0] gpi_i,
  output logic [N_GPI-1:0] rise_o
);
  localparam int unsigned STAGES = 3; // two sync flops plus one for edge detect

  for (genvar i = 0; i < N_GPI; i++) begin : g_bit
    logic [STAGES-1:0] stg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], gpi_i[i]};
    end

    assign rise_o[i] = stg_q[1] & ~stg_q[2];
  end
endmodule

// File: rtl/gpi_sts_bank.sv
module gpi_sts_bank #(
  parameter int unsigned     N_GPI     = 16,
  parameter logic [N_GPI-1:0] IMPL_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_wr_i,
  input  logic             sts_wr_i,
  input  logic [N_GPI-1:0] wdata_i,
  input  logic [N_GPI-1:0] rise_i,
  output logic [N_GPI-1:0] en_o,
  output logic [N_GPI-1:0] sts_o
);
  logic [N_GPI-1:0] en_q, sts_q, clr;

  assign clr = sts_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wdata_i & IMPL_MASK;
      // set has priority over a simultaneous clear
      sts_q <= ((sts_q & ~clr) | rise_i) & IMPL_MASK;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/gpi_smi_gate.sv
module gpi_smi_gate
  import gpi_smi_pkg::*;
#(
  parameter int unsigned      N_GPI     = 16,
  parameter logic [N_GPI-1:0] IMPL_MASK = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_GPI*ROUTE_W-1:0] route_i,
  input  logic [N_GPI-1:0]         en_i,
  input  logic [N_GPI-1:0]         sts_i,
  input  logic                     gpe_clr_i,
  output logic                     smi_no_o,
  output logic                     gpe_sts_o
);
  logic [N_GPI-1:0] to_smi;
  logic             pend;
  logic             gpe_q;

  for (genvar i = 0; i < N_GPI; i++) begin : g_route
    assign to_smi[i] = (route_i[i*ROUTE_W +: ROUTE_W] == ROUTE_SMI);
  end

  assign pend = |(sts_i & en_i & to_smi & IMPL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gpe_q <= 1'b0;
    else         gpe_q <= pend | (gpe_q & ~gpe_clr_i);
  end

  assign smi_no_o  = ~pend;
  assign gpe_sts_o = gpe_q | pend;
endmodule

// File: rtl/gpi_smi_regs.sv
module gpi_smi_regs
  import gpi_smi_pkg::*;
#(
  parameter int unsigned       N_GPI     = 16,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] EN_OFS    = 8'h38,
  parameter logic [ADDR_W-1:0] STS_OFS   = 8'h3A,
  parameter logic [N_GPI-1:0]  IMPL_MASK = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_GPI-1:0]         gpi_i,
  input  logic [N_GPI*ROUTE_W-1:0] route_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [N_GPI-1:0]         wdata_i,
  output logic [N_GPI-1:0]         rdata_o,
  input  logic                     gpe_clr_i,
  output logic                     smi_no_o,
  output logic                     gpe_sts_o
);
  logic [N_GPI-1:0] rise, en_q, sts_q;
  logic             hit_en, hit_sts;

  assign hit_en  = (addr_i == EN_OFS);
  assign hit_sts = (addr_i == STS_OFS);

  gpi_sync #(.N_GPI(N_GPI)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gpi_i  (gpi_i),
    .rise_o (rise)
  );

  gpi_sts_bank #(.N_GPI(N_GPI), .IMPL_MASK(IMPL_MASK)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_wr_i  (wr_i & hit_en),
    .sts_wr_i (wr_i & hit_sts),
    .wdata_i  (wdata_i),
    .rise_i   (rise),
    .en_o     (en_q),
    .sts_o    (sts_q)
  );

  gpi_smi_gate #(.N_GPI(N_GPI), .IMPL_MASK(IMPL_MASK)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .route_i   (route_i),
    .en_i      (en_q),
    .sts_i     (sts_q),
    .gpe_clr_i (gpe_clr_i),
    .smi_no_o  (smi_no_o),
    .gpe_sts_o (gpe_sts_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_en)       rdata_o = en_q;
    else if (hit_sts) rdata_o = sts_q;
  end
endmodule

// File: rtl/gpi_smi_chk.sv
module gpi_smi_chk #(
  parameter int unsigned       N_GPI     = 16,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] EN_OFS    = 8'h38,
  parameter logic [ADDR_W-1:0] STS_OFS   = 8'h3A,
  parameter logic [N_GPI-1:0]  IMPL_MASK = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_GPI-1:0]  wdata_i,
  input logic              gpe_clr_i,
  input logic              smi_no_o,
  input logic              gpe_sts_o,
  input logic [N_GPI-1:0]  en_q,
  input logic [N_GPI-1:0]  sts_q
);
  assert_en_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == EN_OFS) |=> (en_q == ($past(wdata_i) & IMPL_MASK)));

  assert_sts_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == STS_OFS) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_absent_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q | sts_q) & ~IMPL_MASK) == '0);

  assert_smi_needs_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_no_o |-> ((en_q & sts_q) != '0));

  assert_smi_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_no_o |-> gpe_sts_o);

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpe_sts_o && !gpe_clr_i) |=> gpe_sts_o);
endmodule

bind gpi_smi_regs gpi_smi_chk #(
  .N_GPI(N_GPI), .ADDR_W(ADDR_W), .EN_OFS(EN_OFS), .STS_OFS(STS_OFS), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .gpe_clr_i (gpe_clr_i),
  .smi_no_o  (smi_no_o),
  .gpe_sts_o (gpe_sts_o),
  .en_q      (en_q),
  .sts_q     (sts_q)
);

// File: tb/gpi_smi_regs_bench.sv
module gpi_smi_regs_bench;
  localparam logic [15:0] IMPL = 16'hBFF7;
  localparam logic [7:0]  A_EN = 8'h38, A_STS = 8'h3A;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [15:0] gpi = '0, wdata = '0, rdata;
  logic [31:0] route = '0;
  logic        wr = 1'b0, gpe_clr = 1'b0, smi_n, gpe;
  logic [7:0]  addr = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpi_smi_regs #(.IMPL_MASK(IMPL)) u_gpi_smi_regs (
    .clk_i(clk), .rst_ni(rst_ni), .gpi_i(gpi), .route_i(route),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .gpe_clr_i(gpe_clr), .smi_no_o(smi_n), .gpe_sts_o(gpe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    step();
    rst_ni = 1'b1;
    step();

    rd_reg(A_EN, v);  check("R1 reset", v, 16'h0000);
    rd_reg(A_STS, v); check("R2 reset", v, 16'h0000);
    check("R7 reset smi", {15'd0, smi_n}, 16'd1);
    check("R9 reset gpe", {15'd0, gpe}, 16'd0);

    wr_reg(A_EN, 16'hFFFF);
    rd_reg(A_EN, v); check("R6 absent enable bits", v, IMPL);
    wr_reg(A_EN, 16'h0000);
    rd_reg(8'h3C, v); check("R10 other offset", v, 16'h0000);
    rd_reg(8'h00, v); check("R10 offset 0", v, 16'h0000);

    for (int n = 0; n < 16; n++) begin
      for (int r = 0; r < 4; r++) begin
        logic        imp, fire;
        logic [15:0] bitn, expb;
        imp  = IMPL[n];
        fire = imp && (r == 1);
        bitn = 16'(1) << n;
        expb = imp ? bitn : 16'h0000;
        route = 32'(r) << (2 * n);

        wr_reg(A_EN, bitn);
        rd_reg(A_EN, v); check("R1 enable readback", v, expb);

        gpi[n] = 1'b1;
        steps(2);
        rd_reg(A_STS, v); check("R2 not yet set", v, 16'h0000);
        step();
        rd_reg(A_STS, v); check("R2 set after sync", v, expb);
        check("R7 smi vs route", {15'd0, smi_n}, {15'd0, !fire});
        check("R9 gpe with smi", {15'd0, gpe}, {15'd0, fire});

        gpi[n] = 1'b0;
        steps(4);
        rd_reg(A_STS, v); check("R3 sticky", v, expb);

        wr_reg(A_STS, 16'h0000);
        rd_reg(A_STS, v); check("R4 write zero", v, expb);

        if (fire) begin
          gpe_clr = 1'b1; step(); gpe_clr = 1'b0;
          check("R9 clear blocked while pending", {15'd0, gpe}, 16'd1);
        end

        if (imp) begin
          gpi[n] = 1'b1;
          steps(2);
          wr_reg(A_STS, bitn);
          rd_reg(A_STS, v); check("R5 set beats clear", v, bitn);
          gpi[n] = 1'b0;
          steps(4);
        end

        wr_reg(A_STS, ~16'h0000);
        rd_reg(A_STS, v); check("R4 write one clears", v, 16'h0000);
        check("R8 smi released", {15'd0, smi_n}, 16'd1);
        check("R9 gpe held after release", {15'd0, gpe}, {15'd0, fire});

        gpe_clr = 1'b1; step(); gpe_clr = 1'b0;
        check("R9 gpe cleared", {15'd0, gpe}, 16'd0);

        wr_reg(A_EN, 16'h0000);
      end
    end

    finish_run();
  end
endmodule